// File: doc/BRIEF.md
# Two-Pin Event Interrupt Router

This block sits between a motion-sensing core and two push-pull interrupt pins. The core presents eight event lines. Each event sets its own bit in a latched source register. An enable register and a map register then decide whether a latched event reaches a pin, and which pin it reaches. One polarity bit in a format register inverts both pins together. Detecting the events (taps, free-fall, activity and the rest) is not part of this block.

Three of the events are data-related: data-ready, watermark and overrun. Their event lines are levels that stay high while the condition exists. A data-related source bit clears only after the host has read a data register and the condition has gone away. The other five events are treated as strobes. Their source bits stay latched until the host reads the source register.

Host access is a plain register port. A read or write strobe is qualified by an address. Read data is combinational from the registers. A read strobe on a data address is used here only as a clearing cue, and the read data it returns is 0.

Top module: `irq_router`

## Requirements
- R1: After reset, the enable, map, source and polarity state are all zero, both pins are low, and reads of 0x2E, 0x2F, 0x30 and 0x31 return 0.
- R2: A write to 0x2E (enable) or 0x2F (map) reads back exactly. At 0x31 only bit 5 (polarity invert) is stored, and the other bits of 0x31 read as 0.
- R3: A non-data event latches in the source register at the clock edge where its event line is high, whether or not it is enabled. The bits are: 7 data-ready, 6 single tap, 5 double tap, 4 activity, 3 inactivity, 2 free-fall, 1 watermark, 0 overrun. Bits 7, 1 and 0 are data-related.
- R4: A map bit of 0 routes its source to pin 1, and a map bit of 1 routes it to pin 2. Each pin is the OR of its enabled, latched sources, so several sources may drive one pin at once.
- R5: Writing an enable bit to 0 removes that source from both pins starting with the cycle after the write. The source bit still reads back as set at 0x30.
- R6: When bit 5 of 0x31 is 1, both pins are active low, so they sit high when no enabled source is latched.
- R7: A read of 0x30 returns the source bits and then clears the non-data bits at that clock edge. Data-related bits are left unchanged by this read.
- R8: A non-data event whose line is high in the same cycle as a read of 0x30 remains latched after the read.
- R9: A data-related bit stays set while its condition is high, even across data reads. It clears once a data read (address 0x32 to 0x37) has occurred while it was set and its condition is low. Until such a read, it stays set after the condition has dropped.
- R10: Reads of any address outside 0x2E to 0x31 return 0. Writes to 0x30 have no effect on the source register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 8 | Event lines from the sensing core (levels for bits 7, 1, 0; strobes for the rest) |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 6 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data (combinational) |
| int1_o | output | 1 | Interrupt pin 1 |
| int2_o | output | 1 | Interrupt pin 2 |

## Verification
The assertions assume two things about the inputs: the host never raises a read strobe and a write strobe in the same cycle, and all inputs are stable and known from reset release onward. Under those assumptions, one cycle's past inputs fully explain the next cycle's source bits. The bench keeps to this by driving inputs only on falling edges, by using tasks that raise exactly one strobe at a time, and by holding every input at zero while reset is applied.

// File: rtl/irq_router.sv
module irq_router #(
  parameter int AW = 6,
  parameter int NEV = 8,
  parameter logic [NEV-1:0] DATA_CLASS = 8'b1000_0011,
  parameter logic [AW-1:0] A_EN = 6'h2E,
  parameter logic [AW-1:0] A_MAP = 6'h2F,
  parameter logic [AW-1:0] A_SRC = 6'h30,
  parameter logic [AW-1:0] A_FMT = 6'h31,
  parameter logic [AW-1:0] A_DLO = 6'h32,
  parameter logic [AW-1:0] A_DHI = 6'h37,
  parameter int INV_BIT = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NEV-1:0] evt_i,
  input  logic           reg_wr,
  input  logic           reg_rd,
  input  logic [AW-1:0]  reg_addr,
  input  logic [NEV-1:0] reg_wdata,
  output logic [NEV-1:0] reg_rdata,
  output logic           int1_o,
  output logic           int2_o
);
  logic [NEV-1:0] en_q, map_q, src_q, arm_q;
  logic           inv_q;

  wire src_rd  = reg_rd && (reg_addr == A_SRC);
  wire data_rd = reg_rd && (reg_addr >= A_DLO) && (reg_addr <= A_DHI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      map_q <= '0;
      inv_q <= 1'b0;
    end else if (reg_wr) begin
      if (reg_addr == A_EN)  en_q  <= reg_wdata;
      if (reg_addr == A_MAP) map_q <= reg_wdata;
      if (reg_addr == A_FMT) inv_q <= reg_wdata[INV_BIT];
    end
  end

  for (genvar i = 0; i < NEV; i++) begin : g_src
    if (DATA_CLASS[i]) begin : g_data
      wire armed = arm_q[i] || (data_rd && src_q[i]);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          src_q[i] <= 1'b0;
          arm_q[i] <= 1'b0;
        end else if (evt_i[i]) begin
          src_q[i] <= 1'b1;
          arm_q[i] <= armed;
        end else if (armed) begin
          src_q[i] <= 1'b0;
          arm_q[i] <= 1'b0;
        end
      end
    end else begin : g_strobe
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) src_q[i] <= 1'b0;
        else        src_q[i] <= evt_i[i] || (src_q[i] && !src_rd);
      end
      assign arm_q[i] = 1'b0;
    end
  end

  wire [NEV-1:0] live = src_q & en_q;
  assign int1_o = inv_q ^ |(live & ~map_q);
  assign int2_o = inv_q ^ |(live & map_q);

  always_comb begin
    unique case (reg_addr)
      A_EN:    reg_rdata = en_q;
      A_MAP:   reg_rdata = map_q;
      A_SRC:   reg_rdata = src_q;
      A_FMT:   reg_rdata = NEV'(inv_q) << INV_BIT;
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
  parameter int NEV = 8,
  parameter logic [NEV-1:0] DATA_CLASS = 8'b1000_0011
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NEV-1:0] evt_i,
  input logic           src_rd,
  input logic [NEV-1:0] src_q,
  input logic [NEV-1:0] en_q,
  input logic           inv_q,
  input logic           int1_o,
  input logic           int2_o
);
  assert_strobe_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((src_q & $past(evt_i)) == $past(evt_i)));

  assert_idle_pins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((src_q & en_q) == '0) |-> (int1_o == inv_q && int2_o == inv_q));

  assert_active_pin_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((src_q & en_q) != '0) |-> ((int1_o != inv_q) || (int2_o != inv_q)));

  assert_src_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(src_rd) |-> ((src_q & ~DATA_CLASS & ~$past(evt_i)) == '0));

  assert_data_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(src_q) & DATA_CLASS & ~src_q) & ~$past(evt_i)) == ($past(src_q) & DATA_CLASS & ~src_q));

  assert_data_untouched_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(src_q) & DATA_CLASS & $past(evt_i) & ~src_q) == '0));
endmodule

bind irq_router irq_router_chk #(.NEV(NEV), .DATA_CLASS(DATA_CLASS)) chk_i (
  .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .src_rd(src_rd), .src_q(src_q),
  .en_q(en_q), .inv_q(inv_q), .int1_o(int1_o), .int2_o(int2_o)
);

// File: tb/irq_router_tb.sv
module irq_router_tb_top;
  logic clk = 0, rst_n = 0;
  logic [7:0] evt_i = 0, reg_wdata = 0;
  logic reg_wr = 0, reg_rd = 0;
  logic [5:0] reg_addr = 0;
  logic [7:0] reg_rdata;
  logic int1_o, int2_o;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  irq_router dut_i (.clk, .rst_n, .evt_i, .reg_wr, .reg_rd, .reg_addr,
                    .reg_wdata, .reg_rdata, .int1_o, .int2_o);

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [7:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(logic [5:0] a, output logic [7:0] d);
    reg_rd = 1; reg_addr = a; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic pulse(logic [7:0] e);
    evt_i = e; @(negedge clk); evt_i = 0;
  endtask

  task automatic pins(string req, logic e1, logic e2);
    check(req, {6'b0, int2_o, int1_o}, {6'b0, e2, e1});
  endtask

  task automatic t_reset;
    logic [7:0] d;
    pins("R1", 0, 0);
    rd(6'h2E, d); check("R1", d, 0);
    rd(6'h2F, d); check("R1", d, 0);
    rd(6'h30, d); check("R1", d, 0);
    rd(6'h31, d); check("R1", d, 0);
  endtask

  task automatic t_regs;
    logic [7:0] d;
    wr(6'h2E, 8'hA5); wr(6'h2F, 8'h3C); wr(6'h31, 8'hFF);
    rd(6'h2E, d); check("R2", d, 8'hA5);
    rd(6'h2F, d); check("R2", d, 8'h3C);
    rd(6'h31, d); check("R2", d, 8'h20);
    wr(6'h2E, 0); wr(6'h2F, 0); wr(6'h31, 0);
  endtask

  task automatic t_latch;
    logic [7:0] d;
    pulse(8'h10);
    pins("R3", 0, 0);
    rd(6'h30, d); check("R3", d, 8'h10);
    rd(6'h30, d); check("R7", d, 8'h00);
  endtask

  task automatic t_route;
    logic [7:0] d;
    wr(6'h2E, 8'hFF); wr(6'h2F, 8'h08);
    pulse(8'h10); pins("R4", 1, 0);
    pulse(8'h08); pins("R4", 1, 1);
    pulse(8'h04); pins("R4", 1, 1);
    wr(6'h2E, 8'h00); pins("R5", 0, 0);
    rd(6'h30, d); check("R5", d, 8'h1C);
    wr(6'h2E, 8'hFF); pins("R4", 0, 0);
  endtask

  task automatic t_invert;
    logic [7:0] d;
    wr(6'h31, 8'h20); pins("R6", 1, 1);
    pulse(8'h04); pins("R6", 0, 1);
    rd(6'h30, d); pins("R6", 1, 1);
    wr(6'h31, 8'h00); pins("R6", 0, 0);
  endtask

  task automatic t_same;
    logic [7:0] d;
    pulse(8'h20);
    evt_i = 8'h40; rd(6'h30, d); evt_i = 0;
    check("R8", d, 8'h20);
    rd(6'h30, d); check("R8", d, 8'h40);
    rd(6'h30, d); check("R8", d, 8'h00);
  endtask

  task automatic t_data;
    logic [7:0] d;
    evt_i = 8'h80; @(negedge clk);
    rd(6'h30, d); check("R7", d, 8'h80);
    rd(6'h30, d); check("R7", d, 8'h80);
    rd(6'h32, d); rd(6'h30, d); check("R9", d, 8'h80);
    pins("R9", 1, 0);
    evt_i = 0; @(negedge clk);
    rd(6'h30, d); check("R9", d, 8'h00);
    pins("R9", 0, 0);
    evt_i = 8'h01; @(negedge clk); evt_i = 0;
    repeat (3) @(negedge clk);
    rd(6'h30, d); check("R9", d, 8'h01);
    rd(6'h35, d);
    rd(6'h30, d); check("R9", d, 8'h00);
  endtask

  task automatic t_misc;
    logic [7:0] d;
    rd(6'h10, d); check("R10", d, 0);
    rd(6'h33, d); check("R10", d, 0);
    wr(6'h30, 8'hFF);
    rd(6'h30, d); check("R10", d, 0);
    pins("R10", 0, 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset(); t_regs(); t_latch(); t_route();
        t_invert(); t_same(); t_data(); t_misc();
      end
      begin
        repeat (5000) @(negedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule